// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block is the digital half of an eight-channel, eight-bit successive-approximation converter. It runs the binary search: it presents a trial code to an external comparator and DAC, and it steers the channel selector of an external analog multiplexer. It also holds the software-visible registers that configure a run and keep its results.

Every run fills four result slots. The run converts either one channel four times over, or each channel of a four-channel group once. It can stop after those four conversions or repeat without end. A write to the control register starts a run, and a power-up enable bit in the options register gates all activity.

Top module: `adc_conv_seq`

## Requirements
- R1: Register map, with reads returning data one cycle after the address is presented. Address 0 is control, address 1 is options, and addresses 4 to 7 hold results 1 to 4. Writes to addresses 2 and 3 are ignored.
- R2: Control register layout. Bit 7 is the done flag and is read-only. Bit 6 always reads 0. Bit 5 is the repeat bit, bit 4 is the group bit, and bits 3..0 are the channel field. Bits 5..0 read back exactly as written.
- R3: The done flag sets on the clock edge that stores the fourth result of a run. A run spans 32 cycles from the write edge, so a held control read first shows the flag 33 cycles after that edge.
- R4: Any control write clears the done flag. If the converter is enabled, the same write aborts any run in progress and starts a new run with the new settings. Result slots keep their previous values until a later conversion overwrites them.
- R5: With bit 5 at 0 the block performs one run and then stays idle. With bit 5 at 1 it starts the next run at once, endlessly.
- R6: With bit 4 at 0, the channel given by bits 2..0 is converted four times into results 1 to 4. Bit 3 is stored but has no effect on channel choice.
- R7: With bit 4 at 1, bit 2 selects channels 0-3 (clear) or 4-7 (set). Each channel of the group is converted once, in ascending order, into results 1 to 4. Bits 1..0 are ignored.
- R8: Options bit 7 is the enable bit. Other options bits read 0. While enable is 0 nothing converts: clearing it aborts a running run, and control writes made while it is 0 start nothing.
- R9: Each conversion takes 8 cycles, deciding bits from the MSB down. While a bit is on trial, `trial_code` holds the bits already decided, a 1 at the trial position, and 0 below it. `cmp_hi`=1 (input at or above trial) keeps the bit; 0 clears it. The result is the input code, with 0x00 for the low reference and 0xFF for the high reference.
- R10: Result registers are read-only. Writes to addresses 4 to 7 leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the address |
| chan_sel | output | 3 | Channel selection for the analog multiplexer |
| trial_code | output | 8 | Trial code for the DAC and comparator |
| cmp_hi | input | 1 | Comparator decision: input at or above trial code |

## Verification
The bench measures the exact flag latency. A sequencer that let even one cycle slip between conversions would set the flag late. It converts codes 0x00 and 0xFF, where a search that mishandled the last bit or the first trial would be off by one.

It sets bit 3 and the ignored group bits, so a decoder that leaked them into the channel number would read the wrong inputs. It also aborts runs part-way and disables the converter mid-run, which catches designs that write partial results, keep converting, or fail to clear the flag.

Repeat and single modes are told apart by changing the inputs after a run ends. Results must follow the new inputs only when repeat is set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_CH   = 8;
  localparam int NUM_SLOT = 4;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_OPT  = 3'd1;

  localparam int CTRL_DONE_BIT = 7;
  localparam int CTRL_REP_BIT  = 5;
  localparam int CTRL_GRP_BIT  = 4;
  localparam int OPT_EN_BIT    = 7;
endpackage

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         abort,
  input  logic         again,
  input  logic         cmp_hi,
  output logic         busy,
  output logic [W-1:0] trial_code,
  output logic         finish,
  output logic [W-1:0] result
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] TOP_IDX = IW'(W-1);
  localparam logic [W-1:0]  MSB     = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  code_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;
  logic [W-1:0]  mask;
  logic [W-1:0]  decided;

  assign mask       = {{(W-1){1'b0}}, 1'b1} << idx_q;
  assign decided    = cmp_hi ? code_q : (code_q & ~mask);
  assign finish     = busy_q && (idx_q == '0);
  assign result     = decided;
  assign busy       = busy_q;
  assign trial_code = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (start) begin
      code_q <= MSB;
      idx_q  <= TOP_IDX;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (idx_q == '0) begin
        if (again) begin
          code_q <= MSB;
          idx_q  <= TOP_IDX;
        end else begin
          code_q <= decided;
          busy_q <= 1'b0;
        end
      end else begin
        code_q <= decided | (mask >> 1);
        idx_q  <= idx_q - 1'b1;
      end
    end
  end

  // R9: trial code has the bit under test set and nothing below it
  a_r9_trial_shape: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (trial_code[idx_q] && ((trial_code & (mask - W'(1))) == '0)));

  // R9: one bit decided per cycle, MSB first
  a_r9_step_down: assert property (@(posedge clk) disable iff (rst)
    (busy_q && idx_q != '0 && !start && !abort) |=> (busy_q && idx_q == $past(idx_q) - 1'b1));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] ridx,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int W     = 8,
  parameter int SLOTS = 4,
  parameter int CHW   = 3,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           kick,
  input  logic           abort,
  input  logic           cfg_rep,
  input  logic           cfg_grp,
  input  logic [CHW-1:0] cfg_sel,
  input  logic           cmp_hi,
  output logic [CHW-1:0] chan_sel,
  output logic [W-1:0]   trial_code,
  output logic           busy,
  output logic           res_we,
  output logic [SW-1:0]  res_idx,
  output logic [W-1:0]   res_data,
  output logic           seq_done
);
  logic           rep_q, grp_q;
  logic [CHW-1:0] sel_q;
  logic [SW-1:0]  slot_q, slot_nx;
  logic [CHW-1:0] chan_q;
  logic           start_c, last, again, eng_fin, accept;
  logic [W-1:0]   eng_res;

  function automatic logic [CHW-1:0] chan_of(input logic grp, input logic [CHW-1:0] sel,
                                             input logic [SW-1:0] slot);
    return grp ? {sel[CHW-1:SW], slot} : sel;
  endfunction

  assign start_c  = kick && en;
  assign last     = (slot_q == SW'(SLOTS-1));
  assign again    = !(last && !rep_q);
  assign accept   = eng_fin && !start_c && !abort;
  assign slot_nx  = last ? '0 : slot_q + 1'b1;
  assign res_we   = accept;
  assign res_idx  = slot_q;
  assign res_data = eng_res;
  assign seq_done = accept && last;
  assign chan_sel = chan_q;

  adc_sar_engine #(.W(W)) u_sar (
    .clk(clk), .rst(rst), .start(start_c), .abort(abort), .again(again),
    .cmp_hi(cmp_hi), .busy(busy), .trial_code(trial_code),
    .finish(eng_fin), .result(eng_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q  <= 1'b0;
      grp_q  <= 1'b0;
      sel_q  <= '0;
      slot_q <= '0;
      chan_q <= '0;
    end else if (start_c) begin
      rep_q  <= cfg_rep;
      grp_q  <= cfg_grp;
      sel_q  <= cfg_sel;
      slot_q <= '0;
      chan_q <= chan_of(cfg_grp, cfg_sel, '0);
    end else if (accept) begin
      slot_q <= slot_nx;
      chan_q <= chan_of(grp_q, sel_q, slot_nx);
    end
  end

  // R9: channel held steady while a conversion is deciding bits
  a_r9_chan_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_fin && !start_c && !abort) |=> $stable(chan_sel));

  // R5: a non-repeating run goes idle after its fourth result
  a_r5_single_stops: assert property (@(posedge clk) disable iff (rst)
    (accept && last && !rep_q) |=> !busy);

  // R8: nothing converts while disabled
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |-> !busy);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int CH    = NUM_CH,
  parameter int SLOTS = NUM_SLOT,
  parameter int AW    = ADDR_W,
  localparam int CHW  = $clog2(CH),
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   rd_data,
  output logic [CHW-1:0] chan_sel,
  output logic [W-1:0]   trial_code,
  input  logic           cmp_hi
);
  logic         rep_q, grp_q, done_q, en_q;
  logic [3:0]   chsel_q;
  logic         ctrl_wr, opt_wr, abort, busy;
  logic         res_we, seq_done;
  logic [SW-1:0] res_idx;
  logic [W-1:0] res_data, bank_q, side_d, side_q;
  logic         is_res_q;
  logic         unused_wr;

  assign ctrl_wr   = wr_en && (addr == ADDR_CTRL);
  assign opt_wr    = wr_en && (addr == ADDR_OPT);
  assign abort     = opt_wr && !wr_data[OPT_EN_BIT];
  assign unused_wr = ^wr_data[6:0];

  adc_seq_ctrl #(.W(W), .SLOTS(SLOTS), .CHW(CHW)) u_seq (
    .clk(clk), .rst(rst), .en(en_q), .kick(ctrl_wr), .abort(abort),
    .cfg_rep(wr_data[CTRL_REP_BIT]), .cfg_grp(wr_data[CTRL_GRP_BIT]),
    .cfg_sel(wr_data[CHW-1:0]), .cmp_hi(cmp_hi),
    .chan_sel(chan_sel), .trial_code(trial_code), .busy(busy),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data), .seq_done(seq_done)
  );

  adc_result_bank #(.W(W), .DEPTH(SLOTS)) u_bank (
    .clk(clk), .we(res_we), .widx(res_idx), .wdata(res_data),
    .ridx(addr[SW-1:0]), .rdata(bank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q   <= 1'b0;
      grp_q   <= 1'b0;
      chsel_q <= '0;
      done_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        rep_q   <= wr_data[CTRL_REP_BIT];
        grp_q   <= wr_data[CTRL_GRP_BIT];
        chsel_q <= wr_data[3:0];
        done_q  <= 1'b0;
      end else if (seq_done) begin
        done_q  <= 1'b1;
      end
      if (opt_wr) en_q <= wr_data[OPT_EN_BIT];
    end
  end

  always_comb begin
    side_d = '0;
    if (addr == ADDR_CTRL) side_d = {done_q, 1'b0, rep_q, grp_q, chsel_q};
    else if (addr == ADDR_OPT) side_d = {en_q, 7'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q   <= '0;
      is_res_q <= 1'b0;
    end else begin
      side_q   <= side_d;
      is_res_q <= addr[AW-1];
    end
  end

  assign rd_data = is_res_q ? bank_q : side_q;

  // R4: any control write clears the done flag
  a_r4_write_clears: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> !done_q);

  // R3: flag follows the fourth stored result
  a_r3_flag_sets: assert property (@(posedge clk) disable iff (rst)
    (seq_done && !ctrl_wr) |=> done_q);

  // R8: no search in progress while the enable bit is low
  a_r8_no_search_off: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !busy);
endmodule

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [2:0] chan_sel;
  logic [7:0] trial_code;
  logic       cmp_hi;
  logic [7:0] vin [8];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural analog input: each channel holds a code
  always_comb cmp_hi = (vin[chan_sel] >= trial_code);

  adc_conv_seq u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .chan_sel(chan_sel), .trial_code(trial_code), .cmp_hi(cmp_hi)
  );

  function automatic logic [2:0] exp_chan(input logic [7:0] c, input int slot);
    return c[4] ? {c[2], 2'(slot)} : c[2:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_flag(output int n);
    n = -1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (rd_data[7]) begin n = k; return; end
    end
  endtask

  task automatic check_results(input string req, input logic [7:0] c);
    logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      rd(3'(4 + s), d);
      chk(req, d, vin[exp_chan(c, s)]);
    end
  endtask

  task automatic run_and_check(input string req, input logic [7:0] c);
    int n;
    logic [7:0] d;
    wr(3'd0, c);
    wait_flag(n);
    chk({"R3 flag latency ", req}, n, 33);
    rd(3'd0, d);
    chk({"R2 readback ", req}, d, {1'b1, 1'b0, c[5:0]});
    check_results({"R9 results ", req}, c);
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] keep [4];
    int n;
    void'($urandom(32'h1d5eed));
    for (int i = 0; i < 8; i++) vin[i] = 8'(i * 37 + 5);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    rd(3'd0, d); chk("R2 reset ctrl", d, 8'h00);
    rd(3'd1, d); chk("R8 reset options", d, 8'h00);

    // R8: a control write while disabled starts nothing
    wr(3'd0, 8'h00);
    repeat (40) @(negedge clk);
    chk("R8 no flag while disabled", rd_data[7], 0);

    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk("R8 R1 options readback", d, 8'h80);

    // R6: single channel, bit 3 and bit 6 set but without effect
    vin[3] = 8'h00; vin[0] = 8'hFF;
    run_and_check("R6 single ch3", 8'h4B);
    run_and_check("R6 single ch0", 8'h00);
    // R7: groups, low bits ignored
    vin[1] = 8'hFF; vin[2] = 8'h00;
    run_and_check("R7 group0", 8'h10);
    run_and_check("R7 group1", 8'h17);

    // R5: single mode stays stopped
    for (int i = 0; i < 4; i++) keep[i] = vin[4 + i];
    for (int i = 4; i < 8; i++) vin[i] = vin[i] ^ 8'h5A;
    repeat (80) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd(3'(4 + s), d); chk("R5 single run stopped", d, keep[s]);
    end

    // random modes, repeat bit clear
    for (int it = 0; it < 8; it++) begin
      for (int i = 0; i < 8; i++) vin[i] = 8'($urandom);
      run_and_check("R6 R7 random", {3'b000, 1'($urandom), 4'($urandom)});
    end

    // R5: repeat mode tracks changed inputs
    run_and_check("R5 repeat group1", 8'h34);
    for (int i = 4; i < 8; i++) vin[i] = 8'($urandom);
    repeat (80) @(negedge clk);
    check_results("R5 repeat follows inputs", 8'h34);

    // R4: write clears flag and aborts, restart measured from second write
    wr(3'd0, 8'h02);
    rd(3'd0, d); chk("R4 flag cleared", d[7], 0);
    vin[5] = 8'h81;
    run_and_check("R4 restart ch5", 8'h05);

    // R4 R8: abort by disable keeps previous results
    for (int s = 0; s < 4; s++) keep[s] = vin[5];
    vin[6] = 8'h3C;
    wr(3'd0, 8'h06);
    repeat (3) @(negedge clk);
    wr(3'd1, 8'h00);
    repeat (40) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd(3'(4 + s), d); chk("R4 R8 results retained", d, keep[s]);
    end
    rd(3'd0, d); chk("R8 no flag after abort", d[7], 0);
    wr(3'd0, 8'h01);
    wait_flag(n);
    chk("R8 disabled start ignored", n, -1);
    rd(3'd4, d); chk("R8 result untouched", d, keep[0]);

    // R10 R1: writes to result and spare addresses ignored
    for (int s = 0; s < 4; s++) wr(3'(4 + s), 8'hAA);
    wr(3'd2, 8'hFF);
    for (int s = 0; s < 4; s++) begin
      rd(3'(4 + s), d); chk("R10 result read-only", d, keep[s]);
    end
    rd(3'd2, d); chk("R1 spare address reads 0", d, 8'h00);
    rd(3'd0, d); chk("R1 R2 ctrl after spare write", d, 8'h01);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule